// File: doc/BRIEF.md
# Multi-Port PHY Reset Sequencer

This block sequences resets for a device that holds several PHY ports, eight by default. It watches an asynchronous active-low reset pin and synchronizes it. It counts how long the pin stays low and ignores any pulse shorter than one millisecond. A qualified pulse holds every port in reset while the pin stays low. When the pin rises, the block captures the configuration strap pins and keeps the whole device in reset for two more milliseconds. The millisecond length is a clock-cycle parameter.

No reset is generated internally at power-up. After the sequencer's own logic is initialized, the device stays in reset until a qualified pulse on the pin has completed. Each port also has a self-clearing software reset. A port starts it by writing 1 to bit 15 of its control register at address 0. The bit reads back as 1 for a fixed number of cycles, and during that time only that port's reset output is active. A software reset does not touch the latched straps. A hardware reset that qualifies while a software reset is running cancels it and takes over.

Top module: `psr_seq`

## Requirements
- R1: After `sys_rst_n` is released, `hw_rst` and every `port_rst` bit are 1, and they stay 1 until a qualified pulse on `rst_pin_n` has been followed by its full release delay.
- R2: A low pulse on `rst_pin_n` shorter than LOW_CYC = CYC_PER_MS*MIN_LOW_MS cycles is ignored. `hw_rst`, `strap_le` and `port_rst` stay 0, and `strap_val` is unchanged.
- R3: A low pulse of at least LOW_CYC cycles sets `hw_rst`, `strap_le` and all `port_rst` bits to 1 while the pin stays low.
- R4: After a qualified pulse, `hw_rst` falls exactly REL_CYC + 3 cycles after the pin rises, where REL_CYC = CYC_PER_MS*RELEASE_MS. The 3 cycles are two synchronizer stages plus one state update.
- R5: `strap_le` is 1 only while a qualified low is held. `strap_val` takes the value of `strap_pins` at the cycle the synchronized pin rises and holds it until the next hardware reset.
- R6: A cycle with `wr_en[p]`=1, `wr_addr`=0 and `wr_swr_bit`=1 (bit 15 of the control register) makes `swr_bit[p]` and `port_rst[p]` read 1 from the next cycle for exactly SW_CYCLES cycles. They then clear by themselves.
- R7: A software reset of port p leaves `port_rst` and `swr_bit` of all other ports at 0, and leaves `strap_val` unchanged.
- R8: A write with `wr_addr` not 0, or with `wr_swr_bit`=0, starts no software reset.
- R9: A start write to a port whose software reset is already running is ignored and does not extend it.
- R10: A hardware reset that qualifies during a software reset clears that port's `swr_bit` in the cycle after `hw_rst` rises.
- R11: While `hw_rst` is 1, start writes are ignored and `swr_bit` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| sys_rst_n | input | 1 | Initializes the sequencer logic; leaves the device held in reset |
| rst_pin_n | input | 1 | Asynchronous active-low hardware reset pin |
| strap_pins | input | STRAP_W | Configuration strap inputs |
| wr_en | input | NUM_PORTS | Per-port register write strobe |
| wr_addr | input | 5 | Register address of the write |
| wr_swr_bit | input | 1 | Value written to bit 15 (software reset) |
| hw_rst | output | 1 | Device-wide hardware reset |
| strap_le | output | 1 | Strap latch enable, high while a qualified low is held |
| strap_val | output | STRAP_W | Latched strap values |
| swr_bit | output | NUM_PORTS | Read-back value of each port's software reset bit |
| port_rst | output | NUM_PORTS | Per-port reset, hardware or software |

## Verification
Pulse lengths are drawn at random on both sides of the qualification threshold. Directed pulses of exactly LOW_CYC-1 and LOW_CYC cycles pin down where the threshold sits, and the release delay is checked on both sides of its exact falling cycle. Random writes on random ports, with random addresses and random values for bit 15, separate real start writes from look-alikes and confirm that the reset stays on one port. Directed overlaps check three cases: a second write during a software reset, a hardware reset arriving during one, and writes made while the device is held in reset.

// File: rtl/psr_pkg.sv
package psr_pkg;
    typedef enum logic [1:0] {
        QS_IDLE    = 2'd0,
        QS_LOWCHK  = 2'd1,
        QS_HOLD    = 2'd2,
        QS_RELEASE = 2'd3
    } qual_state_e;

    localparam int unsigned CTRL_AW   = 5;
    localparam logic [CTRL_AW-1:0] CTRL_ADDR = '0;
endpackage

// File: rtl/psr_pin_qual.sv
module psr_pin_qual
    import psr_pkg::*;
#(
    parameter int unsigned LOW_CYC = 25000,
    parameter int unsigned REL_CYC = 50000
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic pin_n,
    output logic hw_rst,
    output logic hold,
    output logic capture
);
    localparam int unsigned MAXC = (LOW_CYC > REL_CYC) ? LOW_CYC : REL_CYC;
    localparam int unsigned CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LOW_LAST = CW'(LOW_CYC - 1);
    localparam logic [CW-1:0] REL_LAST = CW'(REL_CYC - 1);

    typedef struct packed {
        logic [1:0]  sync;
        qual_state_e state;
        logic [CW-1:0] cnt;
        logic        armed;
    } qual_regs_t;

    qual_regs_t r_q, r_d;
    logic pin_s;

    assign pin_s = r_q.sync[1];

    always_comb begin
        r_d = r_q;
        r_d.sync = {r_q.sync[0], pin_n};
        case (r_q.state)
            QS_IDLE: begin
                if (!pin_s) begin
                    r_d.state = QS_LOWCHK;
                    r_d.cnt   = CW'(1);
                end
            end
            QS_LOWCHK: begin
                if (pin_s) begin
                    r_d.state = QS_IDLE;
                    r_d.cnt   = '0;
                end else if (r_q.cnt == LOW_LAST) begin
                    r_d.state = QS_HOLD;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            QS_HOLD: begin
                if (pin_s) begin
                    r_d.state = QS_RELEASE;
                    r_d.cnt   = '0;
                end
            end
            default: begin
                if (r_q.cnt == REL_LAST) begin
                    r_d.state = QS_IDLE;
                    r_d.cnt   = '0;
                    r_d.armed = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            r_q.sync  <= 2'b11;
            r_q.state <= QS_IDLE;
            r_q.cnt   <= '0;
            r_q.armed <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hold    = (r_q.state == QS_HOLD);
    assign capture = (r_q.state == QS_HOLD) && pin_s;
    assign hw_rst  = !r_q.armed || (r_q.state == QS_HOLD) || (r_q.state == QS_RELEASE);

    AST_QUAL_AFTER_FULL_LOW: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (r_q.state == QS_HOLD && $past(r_q.state) == QS_LOWCHK) |-> $past(r_q.cnt) == LOW_LAST); // R3
    AST_RELEASE_FULL_DELAY: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (r_q.state == QS_IDLE && $past(r_q.state) == QS_RELEASE) |-> $past(r_q.cnt) == REL_LAST); // R4
    AST_NO_SHORT_QUAL: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (r_q.state == QS_LOWCHK && r_q.cnt != LOW_LAST) |=> r_q.state != QS_HOLD); // R2
endmodule

// File: rtl/psr_strap_latch.sv
module psr_strap_latch #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         sys_rst_n,
    input  logic         capture,
    input  logic [W-1:0] strap_in,
    output logic [W-1:0] strap_q
);
    typedef struct packed {
        logic [W-1:0] val;
    } strap_regs_t;

    strap_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (capture) begin
            r_d.val = strap_in;
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            r_q.val <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign strap_q = r_q.val;

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !capture |=> $stable(strap_q)); // R5
endmodule

// File: rtl/psr_swr_port.sv
module psr_swr_port
    import psr_pkg::*;
#(
    parameter int unsigned SW_CYCLES = 16
) (
    input  logic               clk,
    input  logic               sys_rst_n,
    input  logic               hw_rst,
    input  logic               wr_en,
    input  logic [CTRL_AW-1:0] wr_addr,
    input  logic               wr_swr_bit,
    output logic               busy
);
    localparam int unsigned SCW = $clog2(SW_CYCLES + 1);
    localparam logic [SCW-1:0] SW_LAST = SCW'(SW_CYCLES - 1);

    typedef struct packed {
        logic           busy;
        logic [SCW-1:0] cnt;
    } swr_regs_t;

    swr_regs_t r_q, r_d;
    logic start;

    assign start = wr_en && (wr_addr == CTRL_ADDR) && wr_swr_bit;

    always_comb begin
        r_d = r_q;
        if (hw_rst) begin
            r_d.busy = 1'b0;
            r_d.cnt  = '0;
        end else if (r_q.busy) begin
            if (r_q.cnt == SW_LAST) begin
                r_d.busy = 1'b0;
                r_d.cnt  = '0;
            end else begin
                r_d.cnt = r_q.cnt + SCW'(1);
            end
        end else if (start) begin
            r_d.busy = 1'b1;
            r_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            r_q.busy <= 1'b0;
            r_q.cnt  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = r_q.busy;

    AST_SWR_FULL_LENGTH: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ($fell(r_q.busy) && !$past(hw_rst)) |-> $past(r_q.cnt) == SW_LAST); // R6
    AST_HW_CANCELS_SWR: assert property (@(posedge clk) disable iff (!sys_rst_n)
        hw_rst |=> !r_q.busy); // R10
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (r_q.busy && r_q.cnt != SW_LAST && !hw_rst) |=> r_q.cnt == $past(r_q.cnt) + SCW'(1)); // R9
endmodule

// File: rtl/psr_seq.sv
module psr_seq
    import psr_pkg::*;
#(
    parameter int unsigned NUM_PORTS  = 8,
    parameter int unsigned STRAP_W    = 6,
    parameter int unsigned CYC_PER_MS = 25000,
    parameter int unsigned MIN_LOW_MS = 1,
    parameter int unsigned RELEASE_MS = 2,
    parameter int unsigned SW_CYCLES  = 16
) (
    input  logic                 clk,
    input  logic                 sys_rst_n,
    input  logic                 rst_pin_n,
    input  logic [STRAP_W-1:0]   strap_pins,
    input  logic [NUM_PORTS-1:0] wr_en,
    input  logic [4:0]           wr_addr,
    input  logic                 wr_swr_bit,
    output logic                 hw_rst,
    output logic                 strap_le,
    output logic [STRAP_W-1:0]   strap_val,
    output logic [NUM_PORTS-1:0] swr_bit,
    output logic [NUM_PORTS-1:0] port_rst
);
    localparam int unsigned LOW_CYC = CYC_PER_MS * MIN_LOW_MS;
    localparam int unsigned REL_CYC = CYC_PER_MS * RELEASE_MS;

    logic capture;

    psr_pin_qual #(
        .LOW_CYC(LOW_CYC),
        .REL_CYC(REL_CYC)
    ) u_qual (
        .clk      (clk),
        .sys_rst_n(sys_rst_n),
        .pin_n    (rst_pin_n),
        .hw_rst   (hw_rst),
        .hold     (strap_le),
        .capture  (capture)
    );

    psr_strap_latch #(
        .W(STRAP_W)
    ) u_strap (
        .clk      (clk),
        .sys_rst_n(sys_rst_n),
        .capture  (capture),
        .strap_in (strap_pins),
        .strap_q  (strap_val)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        psr_swr_port #(
            .SW_CYCLES(SW_CYCLES)
        ) u_swr (
            .clk       (clk),
            .sys_rst_n (sys_rst_n),
            .hw_rst    (hw_rst),
            .wr_en     (wr_en[p]),
            .wr_addr   (wr_addr),
            .wr_swr_bit(wr_swr_bit),
            .busy      (swr_bit[p])
        );

        AST_SWR_GATED_BY_HW: assert property (@(posedge clk) disable iff (!sys_rst_n)
            $rose(swr_bit[p]) |-> !$past(hw_rst)); // R11
    end

    always_comb begin
        port_rst = swr_bit | {NUM_PORTS{hw_rst}};
    end
endmodule

// File: tb/sim_psr_seq.sv
module sim_psr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 8;
    localparam int SW  = 6;
    localparam int CPM = 8;
    localparam int LOW = CPM * 1;
    localparam int REL = CPM * 2;
    localparam int SWC = 16;

    logic clk = 1'b0;
    logic sys_rst_n = 1'b0;
    logic rst_pin_n = 1'b1;
    logic [SW-1:0] strap_pins = '0;
    logic [NP-1:0] wr_en = '0;
    logic [4:0] wr_addr = '0;
    logic wr_swr_bit = 1'b0;
    logic hw_rst, strap_le;
    logic [SW-1:0] strap_val;
    logic [NP-1:0] swr_bit, port_rst;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psr_seq #(
        .NUM_PORTS(NP), .STRAP_W(SW), .CYC_PER_MS(CPM),
        .MIN_LOW_MS(1), .RELEASE_MS(2), .SW_CYCLES(SWC)
    ) u0 (
        .clk(clk), .sys_rst_n(sys_rst_n), .rst_pin_n(rst_pin_n),
        .strap_pins(strap_pins), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_swr_bit(wr_swr_bit), .hw_rst(hw_rst), .strap_le(strap_le),
        .strap_val(strap_val), .swr_bit(swr_bit), .port_rst(port_rst)
    );

    function automatic bit starts_swr(logic [4:0] a, logic b15);
        return (a == 5'd0) && b15;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(int p, logic [4:0] a, logic b15);
        wr_en = '0;
        wr_en[p] = 1'b1;
        wr_addr = a;
        wr_swr_bit = b15;
        tick(1);
        wr_en = '0;
        wr_addr = '0;
        wr_swr_bit = 1'b0;
    endtask

    task automatic full_hw_reset(logic [SW-1:0] s);
        strap_pins = s;
        rst_pin_n = 1'b0;
        tick(LOW + 5);
        rst_pin_n = 1'b1;
        tick(REL + 6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int len;
        int hi;
        int p;
        logic [4:0] a;
        logic b;
        logic [SW-1:0] s_old;
        void'($urandom(32'h5EED_0042));
        tick(3);
        sys_rst_n = 1'b1;
        tick(2);
        // R1: held in reset with no pulse yet
        chk("R1 hw_rst after init", hw_rst, 1);
        chk("R1 port_rst after init", port_rst, {NP{1'b1}});
        write(2, 5'd0, 1'b1);
        tick(1);
        // R11: writes ignored while held
        chk("R11 swr ignored in hw reset", swr_bit, 0);
        tick(40);
        chk("R1 still held without pulse", hw_rst, 1);

        // R3, R4, R5: qualified pulse with exact release timing
        strap_pins = 6'h2D;
        rst_pin_n = 1'b0;
        tick(LOW + 5);
        chk("R3 hw_rst during long low", hw_rst, 1);
        chk("R3 strap_le during long low", strap_le, 1);
        chk("R3 all ports reset", port_rst, {NP{1'b1}});
        rst_pin_n = 1'b1;
        tick(REL + 2);
        chk("R4 hw_rst one cycle before release", hw_rst, 1);
        chk("R5 strap_le low after pin rises", strap_le, 0);
        tick(1);
        chk("R4 hw_rst at release", hw_rst, 0);
        chk("R5 strap captured", strap_val, 6'h2D);
        strap_pins = 6'h12;
        tick(3);
        chk("R5 strap held after pins change", strap_val, 6'h2D);
        chk("R4 ports out of reset", port_rst, 0);

        // R2: threshold pulse of LOW-1 ignored
        rst_pin_n = 1'b0;
        tick(LOW - 1);
        rst_pin_n = 1'b1;
        tick(8);
        chk("R2 pulse LOW-1 ignored hw_rst", hw_rst, 0);
        chk("R2 pulse LOW-1 strap unchanged", strap_val, 6'h2D);
        // R3: exactly LOW qualifies
        strap_pins = 6'h0F;
        rst_pin_n = 1'b0;
        tick(LOW);
        rst_pin_n = 1'b1;
        tick(2);
        chk("R3 pulse of exactly LOW qualifies", hw_rst, 1);
        tick(REL + 6);
        chk("R5 strap from exact pulse", strap_val, 6'h0F);

        // R2 random short pulses
        for (int i = 0; i < 10; i++) begin
            len = 1 + int'($urandom_range(LOW - 2));
            strap_pins = 6'($urandom);
            rst_pin_n = 1'b0;
            hi = 0;
            for (int k = 0; k < len; k++) begin
                tick(1);
                hi = hi | int'(hw_rst) | int'(strap_le) | int'(|port_rst);
            end
            rst_pin_n = 1'b1;
            tick(5);
            chk("R2 short pulse no reset", hi, 0);
            chk("R2 short pulse straps kept", strap_val, 6'h0F);
        end

        // R6: exact length on a directed port
        write(3, 5'd0, 1'b1);
        hi = 0;
        while (swr_bit[3] && hi < 100) begin
            chk("R7 only port 3 reset", port_rst, 8'h08);
            hi++;
            tick(1);
        end
        chk("R6 swr length", hi, SWC);
        chk("R7 straps untouched by swr", strap_val, 6'h0F);

        // R9: second write during reset does not extend it
        write(5, 5'd0, 1'b1);
        hi = 0;
        while (swr_bit[5] && hi < 100) begin
            hi++;
            if (hi == 5) write(5, 5'd0, 1'b1);
            else tick(1);
        end
        chk("R9 rewrite does not extend", hi, SWC);

        // R6, R7, R8: random writes
        for (int i = 0; i < 30; i++) begin
            p = int'($urandom_range(NP - 1));
            a = ($urandom_range(1) == 0) ? 5'd0 : 5'($urandom);
            b = 1'($urandom);
            write(p, a, b);
            chk("R8/R6 start decode", swr_bit, starts_swr(a, b) ? (8'h1 << p) : 8'h0);
            chk("R7 port_rst isolation", port_rst, starts_swr(a, b) ? (8'h1 << p) : 8'h0);
            tick(SWC + 2);
            chk("R6 self-clear", swr_bit, 0);
        end

        // R10: hardware reset cancels running software reset
        rst_pin_n = 1'b0;
        tick(1);
        write(6, 5'd0, 1'b1);
        chk("R10 swr started before qualify", swr_bit, 8'h40);
        tick(LOW + 2);
        chk("R10 hw_rst asserted", hw_rst, 1);
        chk("R10 swr cancelled", swr_bit, 0);
        write(1, 5'd0, 1'b1);
        tick(1);
        chk("R11 write during hw hold ignored", swr_bit, 0);
        rst_pin_n = 1'b1;
        tick(REL + 6);
        chk("R10 after release all idle", port_rst, 0);

        // random long pulses re-latch straps
        for (int i = 0; i < 4; i++) begin
            s_old = 6'($urandom);
            full_hw_reset(s_old);
            chk("R5 strap re-latched", strap_val, s_old);
            chk("R4 released", hw_rst, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule